// File: doc/BRIEF.md
# Four-Entry Master Data Byte Buffer

This block is the byte staging store that sits behind one data register of a serial bus master. Software pushes bytes that are to be transmitted by writing that register, and pulls bytes that were received by reading it. Four bytes fit in the store. A fill position runs from "empty" through entry 0 up to entry 3 ("full"). The block drives two status flags from that position: one says data is present and one says the store is full.

A read always presents entry 0. When the store holds data, taking the read shifts every remaining byte one place toward entry 0. After a read transfer the transfer sequencer can replace the whole content in one cycle through a parallel load port. Mode control can empty the store with a one-cycle flush pulse.

The read data is combinational from the current state. Every state change takes effect at the rising clock edge in the cycle where its strobe is high. Reset is synchronous and active high.

Top module: `byte_stage_buffer`

## Requirements
- R1: After reset the store is empty, both flags are 0, and `rd_data` shows 8'hFF.
- R2: While the store is empty, `rd_data` is 8'hFF. A read strobe taken while empty changes no state.
- R3: A write taken while not full stores `wr_data` one place above the current top, or at entry 0 when the store is empty. Reads then return the bytes in the order they were written.
- R4: A write taken while full is dropped. Content and flags are unchanged.
- R5: The has-data flag rises on the write that fills entry 0. It falls on the read taken while only entry 0 is occupied.
- R6: The full flag rises on the write that fills entry 3. It falls on the first read taken while full.
- R7: A flush pulse empties the store, zeroes every entry and clears both flags.
- R8: A load with count n stores `ld_data[8i+7:8i]` into entry i for every i < n, and the store then holds exactly n bytes. The has-data flag becomes (n >= 1) and the full flag becomes (n == 4). A count above 4 is treated as 4.
- R9: When several commands arrive in one cycle, only the first in the order flush, load, read, write is taken. The others are ignored.
- R10: `rd_data` shows entry 0 in the same cycle as the read strobe. The shift appears after the clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_stb | input | 1 | Data register read strobe |
| wr_stb | input | 1 | Data register write strobe |
| wr_data | input | 8 | Byte written by software |
| flush | input | 1 | Empty-and-clear command pulse |
| ld_stb | input | 1 | Parallel load strobe from the transfer sequencer |
| ld_count | input | 3 | Number of bytes in the load (values above 4 clamp to 4) |
| ld_data | input | 32 | Load bytes, byte i at bits 8i+7:8i |
| rd_data | output | 8 | Entry 0, or 8'hFF when empty |
| has_data | output | 1 | Store holds at least one byte |
| full | output | 1 | Store holds four bytes |

## Verification
On every cycle the assertions check these relations between the flags, the read data and the commands:
- the full flag implies the has-data flag, and an empty store reads 8'hFF;
- flushes and loads leave the flags required by R7 and R8;
- a dropped write or an empty read leaves the state unchanged.

Only the bench scenarios can show the rest:
- byte ordering across writes and shifts, including the order after a parallel load;
- the exact read at which each flag falls;
- the priority between commands that collide in one cycle.

// File: rtl/mdb_pkg.sv
package mdb_pkg;

    parameter int MDB_DATA_W = 8;
    parameter int MDB_DEPTH  = 4;

    // Command selected for the current cycle after priority resolution.
    typedef enum logic [2:0] {
        CMD_IDLE  = 3'd0,
        CMD_FLUSH = 3'd1,
        CMD_LOAD  = 3'd2,
        CMD_READ  = 3'd3,
        CMD_WRITE = 3'd4
    } mdb_cmd_e;

    // Limit a requested load count to the store depth.
    function automatic int unsigned clamp_count(input int unsigned req, input int unsigned depth);
        return (req > depth) ? depth : req;
    endfunction

endpackage

// File: rtl/mdb_arbiter.sv
module mdb_arbiter
    import mdb_pkg::*;
(
    input  logic     rd_stb,
    input  logic     wr_stb,
    input  logic     flush,
    input  logic     ld_stb,
    input  logic     live,
    input  logic     at_top,
    output mdb_cmd_e cmd
);
    // Priority: flush, load, read, write. Empty reads and full writes become idle.
    always_comb begin
        cmd = CMD_IDLE;
        if (flush) begin
            cmd = CMD_FLUSH;
        end else if (ld_stb) begin
            cmd = CMD_LOAD;
        end else if (rd_stb) begin
            cmd = live ? CMD_READ : CMD_IDLE;
        end else if (wr_stb) begin
            cmd = (live && at_top) ? CMD_IDLE : CMD_WRITE;
        end
    end
endmodule

// File: rtl/mdb_fill_track.sv
module mdb_fill_track
    import mdb_pkg::*;
#(
    parameter int DEPTH = MDB_DEPTH,
    localparam int POS_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  mdb_cmd_e         cmd,
    input  logic [CNT_W-1:0] ld_n,
    output logic             live,
    output logic [POS_W-1:0] pos,
    output logic             has_data,
    output logic             full
);
    localparam logic [POS_W-1:0] TOP_POS = POS_W'(DEPTH - 1);

    logic             live_q, live_d;
    logic [POS_W-1:0] pos_q, pos_d;
    logic             hd_q, hd_d;
    logic             full_q, full_d;

    always_comb begin
        live_d = live_q;
        pos_d  = pos_q;
        hd_d   = hd_q;
        full_d = full_q;
        unique case (cmd)
            CMD_FLUSH: begin
                live_d = 1'b0;
                pos_d  = '0;
                hd_d   = 1'b0;
                full_d = 1'b0;
            end
            CMD_LOAD: begin
                live_d = (ld_n != '0);
                pos_d  = (ld_n != '0) ? POS_W'(ld_n - 1'b1) : '0;
                hd_d   = (ld_n != '0);
                full_d = (ld_n == CNT_W'(DEPTH));
            end
            CMD_READ: begin
                if (pos_q == '0) begin
                    live_d = 1'b0;
                    hd_d   = 1'b0;
                end else begin
                    pos_d = pos_q - 1'b1;
                end
                if (pos_q == TOP_POS) begin
                    full_d = 1'b0;
                end
            end
            CMD_WRITE: begin
                live_d = 1'b1;
                pos_d  = live_q ? pos_q + 1'b1 : '0;
                if (!live_q) begin
                    hd_d = 1'b1;
                end
                if (pos_d == TOP_POS) begin
                    full_d = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= 1'b0;
            pos_q  <= '0;
            hd_q   <= 1'b0;
            full_q <= 1'b0;
        end else begin
            live_q <= live_d;
            pos_q  <= pos_d;
            hd_q   <= hd_d;
            full_q <= full_d;
        end
    end

    assign live     = live_q;
    assign pos      = pos_q;
    assign has_data = hd_q;
    assign full     = full_q;
endmodule

// File: rtl/mdb_store.sv
module mdb_store
    import mdb_pkg::*;
#(
    parameter int DATA_W = MDB_DATA_W,
    parameter int DEPTH  = MDB_DEPTH,
    localparam int POS_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  mdb_cmd_e                cmd,
    input  logic [POS_W-1:0]        wr_pos,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic [CNT_W-1:0]        ld_n,
    input  logic [DATA_W*DEPTH-1:0] ld_data,
    output logic [DATA_W-1:0]       head
);
    logic [DATA_W-1:0] ent_q [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
        logic [DATA_W-1:0] above;
        logic [DATA_W-1:0] nxt;

        if (gi < DEPTH - 1) begin : g_mid
            assign above = ent_q[gi+1];
        end else begin : g_last
            assign above = '0;
        end

        always_comb begin
            nxt = ent_q[gi];
            unique case (cmd)
                CMD_FLUSH: nxt = '0;
                CMD_LOAD:  if (CNT_W'(gi) < ld_n) nxt = ld_data[gi*DATA_W +: DATA_W];
                CMD_READ:  nxt = above;
                CMD_WRITE: if (wr_pos == POS_W'(gi)) nxt = wr_data;
                default: ;
            endcase
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q[gi] <= '0;
            end else begin
                ent_q[gi] <= nxt;
            end
        end
    end

    assign head = ent_q[0];
endmodule

// File: rtl/byte_stage_buffer.sv
module byte_stage_buffer
    import mdb_pkg::*;
#(
    parameter int DATA_W = MDB_DATA_W,
    parameter int DEPTH  = MDB_DEPTH,
    parameter logic [DATA_W-1:0] EMPTY_BYTE = '1,
    localparam int POS_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    rd_stb,
    input  logic                    wr_stb,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic                    flush,
    input  logic                    ld_stb,
    input  logic [CNT_W-1:0]        ld_count,
    input  logic [DATA_W*DEPTH-1:0] ld_data,
    output logic [DATA_W-1:0]       rd_data,
    output logic                    has_data,
    output logic                    full
);
    mdb_cmd_e          cmd;
    logic              live;
    logic [POS_W-1:0]  pos;
    logic [POS_W-1:0]  wr_pos;
    logic [CNT_W-1:0]  ld_n;
    logic [DATA_W-1:0] head;

    assign ld_n   = CNT_W'(clamp_count(int'(ld_count), DEPTH));
    assign wr_pos = live ? pos + 1'b1 : '0;

    mdb_arbiter u_arb (
        .rd_stb (rd_stb),
        .wr_stb (wr_stb),
        .flush  (flush),
        .ld_stb (ld_stb),
        .live   (live),
        .at_top (pos == POS_W'(DEPTH - 1)),
        .cmd    (cmd)
    );

    mdb_fill_track #(.DEPTH(DEPTH)) u_fill (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .ld_n     (ld_n),
        .live     (live),
        .pos      (pos),
        .has_data (has_data),
        .full     (full)
    );

    mdb_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .wr_pos  (wr_pos),
        .wr_data (wr_data),
        .ld_n    (ld_n),
        .ld_data (ld_data),
        .head    (head)
    );

    assign rd_data = live ? head : EMPTY_BYTE;
endmodule

// File: rtl/mdb_checker.sv
module mdb_checker #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 3,
    parameter int DEPTH  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_stb,
    input logic              wr_stb,
    input logic              flush,
    input logic              ld_stb,
    input logic [CNT_W-1:0]  ld_count,
    input logic [DATA_W-1:0] rd_data,
    input logic              has_data,
    input logic              full
);
    AST_EMPTY_READS_ONES: assert property (@(posedge clk) disable iff (rst)
        !has_data |-> rd_data == '1); // R2

    AST_FULL_HAS_DATA: assert property (@(posedge clk) disable iff (rst)
        full |-> has_data); // R6

    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        flush |=> (!has_data && !full)); // R7

    AST_LOAD_FULL: assert property (@(posedge clk) disable iff (rst)
        (ld_stb && !flush && ld_count >= CNT_W'(DEPTH)) |=> full); // R8

    AST_LOAD_NONE: assert property (@(posedge clk) disable iff (rst)
        (ld_stb && !flush && ld_count == '0) |=> !has_data); // R8

    AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && full && !rd_stb && !ld_stb && !flush)
        |=> (full && rd_data == $past(rd_data))); // R4

    AST_EMPTY_READ_INERT: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && !has_data && !ld_stb && !flush) |=> !has_data); // R2

    AST_LOAD_BEATS_READ: assert property (@(posedge clk) disable iff (rst)
        (ld_stb && rd_stb && !flush && ld_count != '0) |=> has_data); // R9
endmodule

bind byte_stage_buffer mdb_checker #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .DEPTH  (DEPTH)
) u_mdb_checker (
    .clk      (clk),
    .rst      (rst),
    .rd_stb   (rd_stb),
    .wr_stb   (wr_stb),
    .flush    (flush),
    .ld_stb   (ld_stb),
    .ld_count (ld_count),
    .rd_data  (rd_data),
    .has_data (has_data),
    .full     (full)
);

// File: tb/test_byte_stage_buffer.sv
module test_byte_stage_buffer;
    logic        clk = 1'b0;
    logic        rst;
    logic        rd_stb, wr_stb, flush, ld_stb;
    logic [7:0]  wr_data;
    logic [2:0]  ld_count;
    logic [31:0] ld_data;
    logic [7:0]  rd_data;
    logic        has_data, full;

    int checks = 0;
    int fails  = 0;
    logic [7:0] model[$];
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    byte_stage_buffer i_byte_stage_buffer (
        .clk(clk), .rst(rst), .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_data(wr_data),
        .flush(flush), .ld_stb(ld_stb), .ld_count(ld_count), .ld_data(ld_data),
        .rd_data(rd_data), .has_data(has_data), .full(full)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: compares rd_data in the strobe cycle (R10) against the scoreboard.
    always @(negedge clk) begin
        if (!rst && rd_stb) begin
            if (exp_q.size() == 0) begin
                check("R10 unexpected read", 32'd1, 32'd0);
            end else begin
                check(tag_q.pop_front(), {24'd0, rd_data}, {24'd0, exp_q.pop_front()});
            end
        end
    end

    // Driver: one command cycle; the model applies priority flush, load, read, write.
    task automatic cmd(input string tag, input logic f, input logic l, input logic [2:0] n,
                       input logic [31:0] ld, input logic r, input logic w, input logic [7:0] wd);
        @(posedge clk); #1;
        flush = f; ld_stb = l; ld_count = n; ld_data = ld;
        rd_stb = r; wr_stb = w; wr_data = wd;
        if (r) begin
            exp_q.push_back(model.size() > 0 ? model[0] : 8'hFF);
            tag_q.push_back(tag);
        end
        if (f) begin
            model.delete();
        end else if (l) begin
            int k;
            k = (n > 4) ? 4 : int'(n);
            model.delete();
            for (int i = 0; i < k; i++) model.push_back(ld[8*i +: 8]);
        end else if (r) begin
            if (model.size() > 0) void'(model.pop_front());
        end else if (w) begin
            if (model.size() < 4) model.push_back(wd);
        end
        @(posedge clk); #1;
        flush = 0; ld_stb = 0; rd_stb = 0; wr_stb = 0;
    endtask

    task automatic flags(input string tag);
        @(negedge clk);
        check({tag, " has_data"}, {31'd0, has_data}, {31'd0, model.size() > 0});
        check({tag, " full"}, {31'd0, full}, {31'd0, model.size() == 4});
        check({tag, " head"}, {24'd0, rd_data}, {24'd0, model.size() > 0 ? model[0] : 8'hFF});
    endtask

    task automatic wr(input string t, input logic [7:0] d); cmd(t, 0, 0, 0, 0, 0, 1, d); endtask
    task automatic rd(input string t);                      cmd(t, 0, 0, 0, 0, 1, 0, 0); endtask

    initial begin
        #(200000 * 4);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst = 1; rd_stb = 0; wr_stb = 0; flush = 0; ld_stb = 0;
        wr_data = 0; ld_count = 0; ld_data = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        flags("R1 reset");

        rd("R2 empty read");             flags("R2 after empty read");
        wr("R3 w0", 8'hA1);              flags("R5 first write");
        wr("R3 w1", 8'hA2);              flags("R3 two");
        wr("R3 w2", 8'hA3);              flags("R3 three");
        wr("R6 w3", 8'hA4);              flags("R6 fourth write");
        wr("R4 full write", 8'hEE);      flags("R4 dropped write");
        rd("R3 read A1");                flags("R6 first read from full");
        rd("R3 read A2");                flags("R3 after read");
        rd("R3 read A3");                flags("R3 one left");
        rd("R3 read A4");                flags("R5 last read");
        rd("R2 empty again");            flags("R2 still empty");

        cmd("R8 load3", 0, 1, 3'd3, 32'h44_33_22_11, 0, 0, 0); flags("R8 load three");
        rd("R8 read 11"); rd("R8 read 22"); rd("R8 read 33"); flags("R8 drained");
        cmd("R8 load7", 0, 1, 3'd7, 32'hD4_C3_B2_A1, 0, 0, 0); flags("R8 clamp full");
        rd("R8 read A1");                flags("R8 after load read");
        cmd("R8 load0", 0, 1, 3'd0, 32'hFFFF_FFFF, 0, 0, 0); flags("R8 load none");

        wr("R7 pre", 8'h5A); wr("R7 pre2", 8'h5B);
        cmd("R7 flush", 1, 0, 0, 0, 0, 0, 0); flags("R7 after flush");
        rd("R7 read after flush");

        cmd("R9 all", 1, 1, 3'd4, 32'h01020304, 1, 1, 8'h77); flags("R9 flush wins");
        cmd("R9 load+read", 0, 1, 3'd2, 32'h0000_9988, 1, 0, 0); flags("R9 load wins");
        cmd("R9 read+write", 0, 0, 0, 0, 1, 1, 8'h66); flags("R9 read wins");
        rd("R9 last 99");                flags("R9 drained");
        wr("R3 refill", 8'h10);          flags("R3 refill");

        repeat (2) @(posedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule